// File: doc/BRIEF.md
# Memory Verify Mismatch Classifier

This block sits behind a read-back path for a UV-erasable memory device. It accepts pairs of bytes, the byte the reference buffer holds and the byte just read from the device, one pair per address, over a sweep of 65,536 addresses starting at address 0. For every pair it works out which bits disagree, and which way each of those bits moved. It then places the address in one of four classes: clean match, under-programmed, unexpected-zero or mixed-direction.

An erased cell reads 1, and programming can only pull a bit from 1 to 0. A bit that should be 0 but reads 1 therefore points at a cell that never took full charge. A bit that should be 1 but reads 0 points at contamination, or at a read of the wrong cell. A byte with both kinds at once points at a corrupted read path rather than at the device.

Across the sweep the block does the following:
- It keeps a saturating counter for each class.
- It holds the address and the two byte values of the first failing address.
- It builds a mask of every bit position that was ever in error.
- It builds a mask of the bit positions that were in error on every byte compared, which marks a suspected stuck data line.
- It ends the sweep with a one-cycle completion pulse.
- It gives a two-bit verdict.

A synchronous start clears all results and opens a new sweep.

Top module: `verify_classifier`

## Requirements
- R1: After reset `in_ready` is 0 and every counter, mask, latch and `verdict` reads 0. A one-cycle `start` clears every result, sets `sweep_addr` to 0 and raises `in_ready` from the next cycle on.
- R2: A pair whose XOR is zero increments `cnt_match` by one.
- R3: A pair whose differing bits are all "expected 0, read 1" (`~exp_byte & rd_byte` nonzero, `exp_byte & ~rd_byte` zero) increments `cnt_under` by one.
- R4: A pair whose differing bits are all "expected 1, read 0" (`exp_byte & ~rd_byte` nonzero, `~exp_byte & rd_byte` zero) increments `cnt_uzero` by one.
- R5: A pair with bits differing in both directions increments `cnt_mixed` by one, and no other counter.
- R6: The first failing pair of a sweep sets `first_valid` and latches its address into `first_addr`, its expected byte into `first_exp` and its read byte into `first_rd`. Later mismatches in the same sweep leave these unchanged.
- R7: `err_mask` is the bitwise OR of the XOR of every pair compared since the last start.
- R8: `stuck_mask` bit i is 1 only when bit i differed on every pair compared since the last start. It is all zero while no pair has been compared.
- R9: A pair is taken when `in_valid` and `in_ready` are both 1 at a clock edge, at most one per cycle. `sweep_addr` advances by one per pair taken and holds during idle cycles.
- R10: The clock edge that takes the pair at address 0xFFFF makes `done` 1 for exactly one cycle and `in_ready` 0 from then on.
- R11: `verdict` encodes the results so far:
  - 00 when no under-programmed, unexpected-zero or mixed byte has been seen;
  - 01 when only under-programmed bytes have been seen;
  - 10 when only unexpected-zero bytes have been seen;
  - 11 when any mixed byte has been seen, or both single-direction classes have.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear all results and open a sweep at address 0 |
| in_valid | input | 1 | A byte pair is present |
| in_ready | output | 1 | A sweep is open and a pair can be taken |
| exp_byte | input | 8 | Byte from the reference buffer |
| rd_byte | input | 8 | Byte read back from the device |
| sweep_addr | output | 16 | Address of the next pair to be taken |
| done | output | 1 | One-cycle pulse after the last address is taken |
| cnt_match | output | 17 | Count of matching bytes |
| cnt_under | output | 17 | Count of under-programmed bytes |
| cnt_uzero | output | 17 | Count of unexpected-zero bytes |
| cnt_mixed | output | 17 | Count of mixed-direction bytes |
| first_valid | output | 1 | A failing byte has been latched |
| first_addr | output | 16 | Address of the first failing byte |
| first_exp | output | 8 | Expected value of the first failing byte |
| first_rd | output | 8 | Read value of the first failing byte |
| err_mask | output | 8 | Bit positions in error on any byte |
| stuck_mask | output | 8 | Bit positions in error on every compared byte |
| verdict | output | 2 | Summary class of the sweep so far |

## Verification
The assertions assume that the source never raises `start` and `in_valid` in the same cycle. They also assume that `start` is only pulsed while the stimulus sits idle. The bench keeps to both: it pulses `start` in its own task between byte streams, with `in_valid` low. Every pair is offered only while `in_ready` is already high. Idle gaps are put in by dropping `in_valid` for whole cycles, so the address-hold and completion-pulse properties see the timing that a real read path would produce.

// File: rtl/vmc_pkg.sv
package vmc_pkg;

    typedef enum logic [1:0] {
        CLS_MATCH = 2'b00,
        CLS_UNDER = 2'b01,
        CLS_UZERO = 2'b10,
        CLS_MIXED = 2'b11
    } byte_class_e;

    localparam int NUM_CLASSES = 4;

    // Class from the two direction flags of one byte.
    function automatic byte_class_e classify(input logic any_up, input logic any_down);
        case ({any_down, any_up})
            2'b00:   return CLS_MATCH;
            2'b01:   return CLS_UNDER;
            2'b10:   return CLS_UZERO;
            default: return CLS_MIXED;
        endcase
    endfunction

    // Sweep verdict from which failure classes have been seen.
    function automatic logic [1:0] verdict_of(input logic seen_up, input logic seen_down,
                                              input logic seen_mixed);
        if (seen_mixed || (seen_up && seen_down)) return 2'b11;
        if (seen_up)   return 2'b01;
        if (seen_down) return 2'b10;
        return 2'b00;
    endfunction

endpackage

// File: rtl/vmc_diff.sv
module vmc_diff
    import vmc_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] exp_b,
    input  logic [DW-1:0] rd_b,
    output logic [DW-1:0] diff,
    output byte_class_e   cls
);
    logic [DW-1:0] up_bits;    // expected 0, read 1
    logic [DW-1:0] down_bits;  // expected 1, read 0

    always_comb begin
        diff      = exp_b ^ rd_b;
        up_bits   = ~exp_b & rd_b;
        down_bits = exp_b & ~rd_b;
        cls       = classify(|up_bits, |down_bits);
    end
endmodule

// File: rtl/vmc_counters.sv
module vmc_counters
    import vmc_pkg::*;
#(
    parameter int NCLS = NUM_CLASSES,
    parameter int CW   = 17
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     inc,
    input  byte_class_e              cls,
    output logic [NCLS-1:0][CW-1:0]  counts
);
    localparam logic [CW-1:0] CMAX = {CW{1'b1}};

    for (genvar k = 0; k < NCLS; k++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                counts[k] <= '0;
            end else if (inc && (int'(cls) == k) && (counts[k] != CMAX)) begin
                counts[k] <= counts[k] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vmc_sweep.sv
module vmc_sweep #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          take,
    input  logic [DW-1:0] exp_b,
    input  logic [DW-1:0] rd_b,
    input  logic [DW-1:0] diff,
    output logic          active,
    output logic [AW-1:0] addr,
    output logic          done,
    output logic          first_valid,
    output logic [AW-1:0] first_addr,
    output logic [DW-1:0] first_exp,
    output logic [DW-1:0] first_rd,
    output logic [DW-1:0] err_mask,
    output logic [DW-1:0] stuck_mask
);
    localparam logic [AW-1:0] LAST_ADDR = {AW{1'b1}};

    logic [DW-1:0] every_acc;
    logic          any_taken;

    always_ff @(posedge clk) begin
        if (rst) begin
            active      <= 1'b0;
            addr        <= '0;
            done        <= 1'b0;
            first_valid <= 1'b0;
            first_addr  <= '0;
            first_exp   <= '0;
            first_rd    <= '0;
            err_mask    <= '0;
            every_acc   <= '1;
            any_taken   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                active      <= 1'b1;
                addr        <= '0;
                first_valid <= 1'b0;
                first_addr  <= '0;
                first_exp   <= '0;
                first_rd    <= '0;
                err_mask    <= '0;
                every_acc   <= '1;
                any_taken   <= 1'b0;
            end else if (take) begin
                addr      <= addr + 1'b1;
                any_taken <= 1'b1;
                err_mask  <= err_mask | diff;
                every_acc <= every_acc & diff;
                if (!first_valid && (diff != '0)) begin
                    first_valid <= 1'b1;
                    first_addr  <= addr;
                    first_exp   <= exp_b;
                    first_rd    <= rd_b;
                end
                if (addr == LAST_ADDR) begin
                    active <= 1'b0;
                    done   <= 1'b1;
                end
            end
        end
    end

    assign stuck_mask = any_taken ? every_acc : '0;
endmodule

// File: rtl/verify_classifier.sv
module verify_classifier
    import vmc_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] exp_byte,
    input  logic [DW-1:0] rd_byte,
    output logic [AW-1:0] sweep_addr,
    output logic          done,
    output logic [CW-1:0] cnt_match,
    output logic [CW-1:0] cnt_under,
    output logic [CW-1:0] cnt_uzero,
    output logic [CW-1:0] cnt_mixed,
    output logic          first_valid,
    output logic [AW-1:0] first_addr,
    output logic [DW-1:0] first_exp,
    output logic [DW-1:0] first_rd,
    output logic [DW-1:0] err_mask,
    output logic [DW-1:0] stuck_mask,
    output logic [1:0]    verdict
);
    logic                           active;
    logic                           take;
    logic [DW-1:0]                  diff;
    byte_class_e                    cls;
    logic [NUM_CLASSES-1:0][CW-1:0] counts;

    assign in_ready = active;
    assign take     = in_valid && active && !start;

    vmc_diff #(.DW(DW)) u_diff (
        .exp_b (exp_byte),
        .rd_b  (rd_byte),
        .diff  (diff),
        .cls   (cls)
    );

    vmc_counters #(.NCLS(NUM_CLASSES), .CW(CW)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clear  (start),
        .inc    (take),
        .cls    (cls),
        .counts (counts)
    );

    vmc_sweep #(.AW(AW), .DW(DW)) u_sweep (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .take        (take),
        .exp_b       (exp_byte),
        .rd_b        (rd_byte),
        .diff        (diff),
        .active      (active),
        .addr        (sweep_addr),
        .done        (done),
        .first_valid (first_valid),
        .first_addr  (first_addr),
        .first_exp   (first_exp),
        .first_rd    (first_rd),
        .err_mask    (err_mask),
        .stuck_mask  (stuck_mask)
    );

    assign cnt_match = counts[CLS_MATCH];
    assign cnt_under = counts[CLS_UNDER];
    assign cnt_uzero = counts[CLS_UZERO];
    assign cnt_mixed = counts[CLS_MIXED];
    assign verdict   = verdict_of(cnt_under != '0, cnt_uzero != '0, cnt_mixed != '0);
endmodule

// File: rtl/verify_classifier_chk.sv
module verify_classifier_chk #(
    parameter int AW = 16,
    parameter int DW = 8,
    parameter int CW = 17
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          in_valid,
    input logic          in_ready,
    input logic [AW-1:0] sweep_addr,
    input logic          done,
    input logic [CW-1:0] cnt_match,
    input logic [CW-1:0] cnt_under,
    input logic [CW-1:0] cnt_uzero,
    input logic [CW-1:0] cnt_mixed,
    input logic          first_valid,
    input logic [AW-1:0] first_addr,
    input logic [DW-1:0] err_mask,
    input logic [DW-1:0] stuck_mask,
    input logic [1:0]    verdict
);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
    // R10
    done_closed_chk: assert property (@(posedge clk) disable iff (rst) done |-> !in_ready);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !start) |=> $stable(sweep_addr));
    // R6
    first_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (first_valid && !start) |=> (first_valid && $stable(first_addr)));
    // R11
    verdict_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (verdict == 2'b00) |-> (cnt_under == '0 && cnt_uzero == '0 && cnt_mixed == '0));
    // R8
    stuck_subset_chk: assert property (@(posedge clk) disable iff (rst)
        (stuck_mask & ~err_mask) == '0);
    // R2
    match_grow_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> (cnt_match >= $past(cnt_match)));
endmodule

bind verify_classifier verify_classifier_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .sweep_addr  (sweep_addr),
    .done        (done),
    .cnt_match   (cnt_match),
    .cnt_under   (cnt_under),
    .cnt_uzero   (cnt_uzero),
    .cnt_mixed   (cnt_mixed),
    .first_valid (first_valid),
    .first_addr  (first_addr),
    .err_mask    (err_mask),
    .stuck_mask  (stuck_mask),
    .verdict     (verdict)
);

// File: tb/verify_classifier_test.sv
module verify_classifier_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  exp_byte = '0;
    logic [7:0]  rd_byte = '0;
    logic [15:0] sweep_addr;
    logic        done;
    logic [16:0] cnt_match, cnt_under, cnt_uzero, cnt_mixed;
    logic        first_valid;
    logic [15:0] first_addr;
    logic [7:0]  first_exp, first_rd, err_mask, stuck_mask;
    logic [1:0]  verdict;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    verify_classifier uut (
        .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
        .exp_byte(exp_byte), .rd_byte(rd_byte), .sweep_addr(sweep_addr), .done(done),
        .cnt_match(cnt_match), .cnt_under(cnt_under), .cnt_uzero(cnt_uzero),
        .cnt_mixed(cnt_mixed), .first_valid(first_valid), .first_addr(first_addr),
        .first_exp(first_exp), .first_rd(first_rd), .err_mask(err_mask),
        .stuck_mask(stuck_mask), .verdict(verdict)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        in_valid = 1'b0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Offer one pair; it is taken at the next rising edge.
    task automatic send(input logic [7:0] e, input logic [7:0] r);
        @(negedge clk);
        exp_byte = e;
        rd_byte  = r;
        in_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic test_reset();
        check("R1 reset ready", in_ready, 0);
        check("R1 reset counters", cnt_match | cnt_under | cnt_uzero | cnt_mixed, 0);
        check("R1 reset latch/masks", {first_valid, first_addr, err_mask, stuck_mask}, 0);
        check("R11 reset verdict", verdict, 2'b00);
    endtask

    // Short partial sweep of unexpected-zero bytes, then a restart.
    task automatic test_partial_uzero();
        pulse_start();
        check("R1 ready after start", in_ready, 1);
        check("R1 address after start", sweep_addr, 0);
        check("R8 stuck mask with nothing compared", stuck_mask, 0);
        for (int i = 0; i < 10; i++) send(8'hFF, 8'hFE);
        idle(1);
        check("R4 uzero count", cnt_uzero, 10);
        check("R11 verdict uzero only", verdict, 2'b10);
        check("R6 first addr", first_addr, 0);
        check("R6 first values", {first_exp, first_rd}, 16'hFFFE);
        check("R8 stuck bit0", stuck_mask, 8'h01);
        check("R9 address after 10", sweep_addr, 10);
        pulse_start();
        check("R1 start clears counters", cnt_uzero | cnt_match, 0);
        check("R1 start clears latch", {first_valid, err_mask, stuck_mask}, 0);
        check("R1 start clears address", sweep_addr, 0);
    endtask

    // Full sweep where bit 4 always reads 1 but is expected 0.
    task automatic test_stuck_sweep();
        pulse_start();
        for (int a = 0; a < 65536; a++) begin
            logic [7:0] e;
            e = 8'(a) & 8'hEF;
            send(e, e | 8'h10);
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 done after last", done, 1);
        check("R10 ready drops", in_ready, 0);
        check("R3 under count", cnt_under, 65536);
        check("R2 no matches", cnt_match, 0);
        check("R8 stuck line bit4", stuck_mask, 8'h10);
        check("R7 err mask", err_mask, 8'h10);
        check("R11 verdict under only", verdict, 2'b01);
        check("R6 first at 0", {first_addr, first_exp, first_rd}, 32'h0000_0010);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
    endtask

    // Full sweep with scattered faults of each class and idle gaps.
    task automatic test_mixed_sweep();
        pulse_start();
        for (int a = 0; a < 65536; a++) begin
            logic [7:0] e, r;
            e = 8'(a) ^ 8'(a >> 8);
            r = e;
            case (a)
                5:      begin e = 8'hA0; r = 8'hA1; end
                100:    begin e = 8'hFF; r = 8'h7F; end
                200:    begin e = 8'hA9; r = 8'hA2; end
                65535:  begin e = 8'h00; r = 8'h04; end
                default: ;
            endcase
            send(e, r);
            if (a % 4096 == 7) begin
                idle(3);
                if (a == 7) check("R9 address holds in gap", sweep_addr, 8);
                if (a == 7) check("R9 ready holds in gap", in_ready, 1);
            end
            if (a == 150) begin
                idle(1);
                check("R6 first latched at 5", {first_addr, first_exp, first_rd}, 32'h0005_A0A1);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 done mixed sweep", done, 1);
        check("R2 match count", cnt_match, 65532);
        check("R3 under count", cnt_under, 2);
        check("R4 uzero count", cnt_uzero, 1);
        check("R5 mixed count", cnt_mixed, 1);
        check("R6 first kept", {first_addr, first_exp, first_rd}, 32'h0005_A0A1);
        check("R7 err mask", err_mask, 8'h8F);
        check("R8 no stuck line", stuck_mask, 8'h00);
        check("R11 verdict mixed", verdict, 2'b11);
        @(negedge clk);
        check("R10 done one cycle", done, 0);
        check("R10 ready stays low", in_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_partial_uzero();
        test_stuck_sweep();
        test_mixed_sweep();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule